// File: doc/BRIEF.md
# Burst Addressing Mode Trap Logic

This block sits in front of a memory controller's command path and inspects the burst addressing mode carried by every incoming access request. Requests that ask for a linear incrementing burst or a cache line wrap burst travel through untouched. A request that carries any other mode code is not refused. It is forwarded with its mode rewritten to linear incrementing, and the block records the event in a sticky trap flag.

The trap flag is the block's only interrupt source. A small register bus gives software four word slots: the raw trap status (write one to clear), the masked status, and an enable set/clear pair. The interrupt output is active high. It follows the raw flag only once the enable has been set.

The request channel is a valid/ready handshake passed straight through with no added latency. The forwarded request appears in the same cycle, and backpressure from downstream reaches the requester combinationally.

Top module: `burst_mode_guard`

## Requirements
- R1: A request whose mode code is 2'b00 (linear) or 2'b01 (wrap) is forwarded in the same cycle with mode, address and length unchanged.
- R2: A request whose mode code is 2'b10 or 2'b11 is forwarded in the same cycle with mode 2'b00 and its address and length unchanged.
- R3: An unsupported-mode request accepted on a clock edge (req_valid and fwd_ready both high) sets the raw trap flag, bit 0 of register index 0, on that edge. An unaccepted request or a supported mode leaves the flag unchanged.
- R4: The raw trap flag is sticky. Writing 1 to bit 0 of index 0 clears it, and writing 0 there has no effect.
- R5: When a trap and a clear write to index 0 fall on the same edge, the flag ends up set.
- R6: Writing 1 to bit 0 of index 2 sets the interrupt enable, and writing 1 to bit 0 of index 3 clears it. Writing 0 to either has no effect. Reads of index 2 or 3 return the enable in bit 0.
- R7: A read of index 1 returns raw flag AND enable in bit 0.
- R8: The irq output is high exactly when both the raw flag and the enable are set.
- R9: fwd_valid equals req_valid and req_ready equals fwd_ready in the same cycle.
- R10: After reset the raw flag, enable and irq are 0, and every read data bit above bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted |
| req_addr | input | ADDR_W | Request start address |
| req_mode | input | 2 | Burst mode code |
| req_len | input | LEN_W | Burst length |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Downstream ready |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_mode | output | 2 | Forwarded burst mode |
| fwd_len | output | LEN_W | Forwarded length |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| irq | output | 1 | Active-high trap interrupt |

## Verification
The bench presents an unsupported request while downstream is stalled. A design that traps on valid alone would set the flag there. It writes zero into the status and enable-clear slots, where a design that treats any write as a clear would lose state. It lands a trap and a clear on the same edge, where a design with the wrong priority would drop the trap. It also confirms that address and length survive the rewrite of mode codes 2 and 3, and that irq stays low while the flag is up with the enable off. A design that ignored the mask would raise irq at that point.

// File: rtl/bmg_pkg.sv
package bmg_pkg;

  typedef enum logic [1:0] {
    BM_LINEAR = 2'b00,
    BM_WRAP   = 2'b01,
    BM_RSVD_A = 2'b10,
    BM_RSVD_B = 2'b11
  } burst_mode_e;

  localparam int unsigned REG_IDX_W = 2;

  localparam logic [REG_IDX_W-1:0] RIDX_RAW    = 2'd0;
  localparam logic [REG_IDX_W-1:0] RIDX_MASKED = 2'd1;
  localparam logic [REG_IDX_W-1:0] RIDX_ENSET  = 2'd2;
  localparam logic [REG_IDX_W-1:0] RIDX_ENCLR  = 2'd3;

  function automatic logic mode_supported(input logic [1:0] m);
    return (m == BM_LINEAR) || (m == BM_WRAP);
  endfunction

endpackage

// File: rtl/bmg_rst_sync.sv
module bmg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/bmg_mode_filter.sv
module bmg_mode_filter
  import bmg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_mode,
  input  logic [LEN_W-1:0]  req_len,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [1:0]        fwd_mode,
  output logic [LEN_W-1:0]  fwd_len,
  output logic              trap_hit
);

  logic legal;

  always_comb begin
    legal     = mode_supported(req_mode);
    fwd_valid = req_valid;
    req_ready = fwd_ready;
    fwd_addr  = req_addr;
    fwd_len   = req_len;
    fwd_mode  = legal ? req_mode : BM_LINEAR;
    trap_hit  = req_valid && fwd_ready && !legal;
  end

  // R1: legal codes pass unchanged
  a_r1_legal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_mode == BM_WRAP)) |-> (fwd_mode == BM_WRAP));

  // R2: illegal codes leave as linear with address kept
  a_r2_trap_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1]) |-> (fwd_mode == BM_LINEAR && fwd_addr == req_addr));

endmodule

// File: rtl/bmg_irq_regs.sv
module bmg_irq_regs
  import bmg_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trap_hit,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq
);

  localparam int unsigned PAD_W = REG_W - 1;

  logic raw_q, raw_nxt, raw_ce;
  logic en_q, en_nxt, en_ce;
  logic raw_clr, en_set, en_clr;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:1];

  always_comb begin
    raw_clr = reg_wr && (reg_idx == RIDX_RAW)   && reg_wdata[0];
    en_set  = reg_wr && (reg_idx == RIDX_ENSET) && reg_wdata[0];
    en_clr  = reg_wr && (reg_idx == RIDX_ENCLR) && reg_wdata[0];

    raw_ce  = trap_hit || raw_clr;
    raw_nxt = trap_hit ? 1'b1 : 1'b0;

    en_ce   = en_set || en_clr;
    en_nxt  = en_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (raw_ce) raw_q <= raw_nxt;
      if (en_ce)  en_q  <= en_nxt;
    end
  end

  always_comb begin
    unique case (reg_idx)
      RIDX_RAW:    reg_rdata = {{PAD_W{1'b0}}, raw_q};
      RIDX_MASKED: reg_rdata = {{PAD_W{1'b0}}, raw_q & en_q};
      default:     reg_rdata = {{PAD_W{1'b0}}, en_q};
    endcase
    irq = raw_q && en_q;
  end

  a_r3_trap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> raw_q);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !(reg_wr && reg_idx == RIDX_RAW && reg_wdata[0])) |=> raw_q);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_hit && raw_clr) |=> raw_q);

  a_r6_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en_q);

  a_r6_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !en_q);

  a_r8_no_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq);

endmodule

// File: rtl/burst_mode_guard.sv
module burst_mode_guard
  import bmg_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned REG_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_mode,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 fwd_valid,
  input  logic                 fwd_ready,
  output logic [ADDR_W-1:0]    fwd_addr,
  output logic [1:0]           fwd_mode,
  output logic [LEN_W-1:0]     fwd_len,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq
);

  logic rst_sync_n;
  logic trap_hit;

  bmg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bmg_mode_filter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_filter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_mode  (req_mode),
    .req_len   (req_len),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_addr  (fwd_addr),
    .fwd_mode  (fwd_mode),
    .fwd_len   (fwd_len),
    .trap_hit  (trap_hit)
  );

  bmg_irq_regs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .trap_hit  (trap_hit),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // R9: handshake passes straight through
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fwd_valid == req_valid) && (req_ready == fwd_ready));

endmodule

// File: tb/burst_mode_guard_test.sv
module burst_mode_guard_test;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int REG_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_mode;
  logic [LEN_W-1:0]  req_len;
  logic              fwd_valid, fwd_ready;
  logic [ADDR_W-1:0] fwd_addr;
  logic [1:0]        fwd_mode;
  logic [LEN_W-1:0]  fwd_len;
  logic              reg_wr;
  logic [1:0]        reg_idx;
  logic [REG_W-1:0]  reg_wdata;
  logic [REG_W-1:0]  reg_rdata;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  burst_mode_guard #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_W(REG_W)) uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [REG_W-1:0] v);
    reg_idx = idx;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [REG_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic send(input logic [1:0] m, input logic rdy, input logic [ADDR_W-1:0] a,
                      input logic [LEN_W-1:0] l, input string req, input logic [1:0] exp_m);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_addr = a; req_len = l; fwd_ready = rdy;
    #1;
    check({req, " mode"}, fwd_mode, exp_m);
    check({req, " addr"}, fwd_addr, a);
    check({req, " len"},  fwd_len, l);
    check("R9 ready", req_ready, rdy);
    @(negedge clk);
    req_valid = 1'b0; fwd_ready = 1'b1;
  endtask

  task automatic t_reset;
    logic [REG_W-1:0] v;
    check("R10 irq", irq, 1'b0);
    rd(2'd0, v); check("R10 raw", v, '0);
    rd(2'd2, v); check("R10 enable", v, '0);
    rd(2'd1, v); check("R10 masked", v, '0);
  endtask

  task automatic t_handshake;
    logic [REG_W-1:0] v;
    @(negedge clk);
    req_valid = 1'b0; fwd_ready = 1'b1; #1;
    check("R9 valid low", fwd_valid, 1'b0);
    req_valid = 1'b1; #1;
    check("R9 valid high", fwd_valid, 1'b1);
    req_valid = 1'b0;
    send(2'b10, 1'b0, 32'h1000_0040, 8'd4, "R2 stalled", 2'b00);
    rd(2'd0, v); check("R3 stalled no trap", v, '0);
  endtask

  task automatic t_legal;
    logic [REG_W-1:0] v;
    send(2'b00, 1'b1, 32'hCAFE_0000, 8'd16, "R1 linear", 2'b00);
    send(2'b01, 1'b1, 32'h0000_BEE0, 8'd8,  "R1 wrap",   2'b01);
    rd(2'd0, v); check("R3 legal no trap", v, '0);
  endtask

  task automatic t_trap;
    logic [REG_W-1:0] v;
    send(2'b10, 1'b1, 32'hDEAD_0010, 8'd3, "R2 code10", 2'b00);
    rd(2'd0, v); check("R3 trap set", v, 32'd1);
    rd(2'd1, v); check("R7 masked off", v, '0);
    check("R8 irq masked", irq, 1'b0);
  endtask

  task automatic t_enable;
    logic [REG_W-1:0] v;
    wr(2'd2, 32'h0);
    rd(2'd2, v); check("R6 set write0", v, '0);
    wr(2'd2, 32'h1);
    rd(2'd2, v); check("R6 enable on", v, 32'd1);
    rd(2'd1, v); check("R7 masked on", v, 32'd1);
    check("R8 irq on", irq, 1'b1);
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd3, v); check("R6 clr write0", v, 32'd1);
    wr(2'd3, 32'h1);
    rd(2'd3, v); check("R6 enable off", v, '0);
    check("R8 irq off", irq, 1'b0);
    rd(2'd0, v); check("R4 raw kept", v, 32'd1);
    wr(2'd2, 32'h1);
  endtask

  task automatic t_clear;
    logic [REG_W-1:0] v;
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, v); check("R4 write0 no clear", v, 32'd1);
    wr(2'd0, 32'h1);
    rd(2'd0, v); check("R4 cleared", v, '0);
    check("R8 irq after clear", irq, 1'b0);
  endtask

  task automatic t_collide;
    logic [REG_W-1:0] v;
    send(2'b11, 1'b1, 32'h0BAD_F00D, 8'd255, "R2 code11", 2'b00);
    check("R8 irq after trap", irq, 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'b11; fwd_ready = 1'b1;
    reg_wr = 1'b1; reg_idx = 2'd0; reg_wdata = 32'h1;
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, v); check("R5 set wins", v, 32'd1);
    wr(2'd0, 32'h1);
    rd(2'd0, v); check("R5 later clear", v, '0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_mode = '0; req_len = '0;
    fwd_ready = 1'b1; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_handshake();
    t_legal();
    t_trap();
    t_enable();
    t_clear();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule